// File: doc/BRIEF.md
# Interrupt Status Aggregation Unit

This unit is the interrupt front end of a storage host controller. Four event sources set bits in a status register: transfer-request completion, task-management completion, link-command completion and error events. Software clears each bit by writing a one to it. An enable register masks the bits. A single interrupt line to the processor is raised whenever an enabled status bit is set.

Transfer-request completions can be grouped. An aggregation stage counts them and sets the transfer-completion status bit once per programmed number of completions. A timeout also sets the bit when a partial group has waited a programmed number of cycles. Software can discard a partial group by writing a flush bit, and typically does so before it inspects which requests finished. A completion that arrives just after the flush starts a new group and can cause an extra interrupt later. Task-management, link and error events are never grouped.

The aggregation stage is a two-state machine. In state AGG_IDLE no group is open. In state AGG_GATHER a partial group is open, and its completion count and elapsed cycles are held there.
- IDLE→IDLE on a completion in bypass mode (aggregation off, or threshold 0 or 1), which fires at once.
- IDLE→GATHER on a completion that is not in bypass mode.
- GATHER→IDLE when the threshold or the timeout is reached, which fires, or on a flush, which does not fire.
- GATHER→GATHER otherwise.
- A flush in either state leads to IDLE.

Registers are reached through a simple synchronous bus with a 32-bit address and 32-bit data. Read data is registered.

Top module: `irq_agg_top`

## Requirements
- R1: The status register is at 0x20. Bit 0 is transfer completion, bit 1 is task-management completion, bit 2 is link-command completion and bit 3 is error. Writing a one to a bit clears it, writing a zero leaves it unchanged, and bits 31:4 read zero.
- R2: The enable register is at 0x24, with bits 3:0 matching the status bits; other bits read zero. `irq` is high exactly when (status AND enable) is nonzero, in the same cycle the registers hold that value.
- R3: `tm_done`, `link_done` and `err_evt` set status bits 1, 2 and 3 on the clock edge where they are sampled high, each on every event, with no grouping.
- R4: The aggregation control register is at 0x28. Bits 4:0 are the threshold, bits 15:8 the timeout in cycles (0 = no timeout), and bit 31 the aggregation enable. Bit 16 is a write-only flush that reads zero. All other bits read zero.
- R5: With aggregation disabled, or a threshold of 0 or 1, every `xfer_done` sets status bit 0 on the edge where it is sampled.
- R6: With aggregation enabled and threshold N≥2, status bit 0 is set on the edge that samples the Nth completion of a group. Fewer than N completions do not set it unless the timeout expires.
- R7: With timeout T≠0, a group opened at edge e sets status bit 0 at edge e+T if the threshold has not been reached by then. The group then closes, and the next completion opens a new group.
- R8: Writing bit 16 of 0x28 discards the open group without setting status bit 0. A completion sampled at the flush edge is dropped, and the next completion opens a new group.
- R9: When a hardware set and a write-one-to-clear hit the same status bit at the same edge, the bit ends up set.
- R10: After reset, all registers, `rdata` and `irq` are zero.
- R11: A read with `rd_en` returns the addressed register on `rdata` after the next edge, reflecting the value before that edge. Unmapped addresses return zero, and `rdata` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 32 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| xfer_done | input | 1 | One transfer request completed this cycle |
| tm_done | input | 1 | One task-management request completed this cycle |
| link_done | input | 1 | Link command completed this cycle |
| err_evt | input | 1 | Error event this cycle |
| irq | output | 1 | Interrupt line to the processor |

## Verification
Every event lands in the status register on the edge that samples it. `irq` follows from the registers in the same cycle, and read data appears one edge after `rd_en`. A threshold hit is therefore visible in the cycle after the Nth completion, and a timeout hit T edges after the edge that opened the group. The bench keeps a behavioural model that advances on every rising edge, and it compares `irq` and `rdata` on every falling edge. Directed reads are issued so that their sampling edge falls on a chosen side of these due edges, which pins the exact cycle of each threshold and timeout result.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NSRC        = 4;
    localparam int SRC_XFER    = 0;
    localparam int SRC_TM      = 1;
    localparam int SRC_LINK    = 2;
    localparam int SRC_ERR     = 3;

    localparam logic [31:0] OFS_STAT = 32'h0000_0020;
    localparam logic [31:0] OFS_EN   = 32'h0000_0024;
    localparam logic [31:0] OFS_AGG  = 32'h0000_0028;

    localparam int AGG_THR_LSB = 0;
    localparam int AGG_TMO_LSB = 8;
    localparam int AGG_RST_BIT = 16;
    localparam int AGG_EN_BIT  = 31;

    typedef enum logic {
        AGG_IDLE   = 1'b0,
        AGG_GATHER = 1'b1
    } agg_state_t;
endpackage

// File: rtl/irq_agg_fsm.sv
module irq_agg_fsm
    import irq_agg_pkg::*;
#(
    parameter int THR_W = 5,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_evt,
    input  logic             agg_on,
    input  logic [THR_W-1:0] thr,
    input  logic [TMO_W-1:0] tmo,
    input  logic             flush,
    output logic             fire,
    output logic             idle
);
    localparam int CNT_W = THR_W + 1;

    agg_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic [TMO_W-1:0] tmr_q, tmr_d, tmr_inc;
    logic             bypass, thr_hit, tmo_hit;

    assign bypass  = !agg_on || (thr <= THR_W'(1));
    assign cnt_inc = cnt_q + CNT_W'(cmp_evt);
    assign tmr_inc = (tmr_q == {TMO_W{1'b1}}) ? tmr_q : tmr_q + TMO_W'(1);
    assign thr_hit = cnt_inc >= {1'b0, thr};
    assign tmo_hit = (tmo != '0) && (tmr_inc >= tmo);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AGG_IDLE;
            cnt_q   <= '0;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tmr_q   <= tmr_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tmr_d   = tmr_q;
        if (flush) begin
            state_d = AGG_IDLE;
            cnt_d   = '0;
            tmr_d   = '0;
        end else begin
            unique case (state_q)
                AGG_IDLE: begin
                    if (cmp_evt && !bypass) begin
                        state_d = AGG_GATHER;
                        cnt_d   = CNT_W'(1);
                        tmr_d   = '0;
                    end
                end
                AGG_GATHER: begin
                    if (thr_hit || tmo_hit) begin
                        state_d = AGG_IDLE;
                        cnt_d   = '0;
                        tmr_d   = '0;
                    end else begin
                        cnt_d = cnt_inc;
                        tmr_d = tmr_inc;
                    end
                end
                default: state_d = AGG_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        fire = 1'b0;
        idle = (state_q == AGG_IDLE);
        unique case (state_q)
            AGG_IDLE:   fire = !flush && cmp_evt && bypass;
            AGG_GATHER: fire = !flush && (thr_hit || tmo_hit);
            default:    fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
    parameter int NBITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set_vec,
    input  logic [NBITS-1:0] clr_vec,
    output logic [NBITS-1:0] stat
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stat[i] <= 1'b0;
            else if (set_vec[i])
                stat[i] <= 1'b1;
            else if (clr_vec[i])
                stat[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int THR_W  = 5,
    parameter int TMO_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              xfer_done,
    input  logic              tm_done,
    input  logic              link_done,
    input  logic              err_evt,
    output logic              irq
);
    logic [NSRC-1:0]   stat_q, en_q, set_vec, clr_vec;
    logic [THR_W-1:0]  thr_q;
    logic [TMO_W-1:0]  tmo_q;
    logic              aon_q;
    logic              hit_stat, hit_en, hit_agg, flush, fire, agg_idle;
    logic [DATA_W-1:0] rd_val, rdata_q;

    assign hit_stat = (addr == ADDR_W'(OFS_STAT));
    assign hit_en   = (addr == ADDR_W'(OFS_EN));
    assign hit_agg  = (addr == ADDR_W'(OFS_AGG));
    assign flush    = wr_en && hit_agg && wdata[AGG_RST_BIT];

    irq_agg_fsm #(.THR_W(THR_W), .TMO_W(TMO_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_evt (xfer_done),
        .agg_on  (aon_q),
        .thr     (thr_q),
        .tmo     (tmo_q),
        .flush   (flush),
        .fire    (fire),
        .idle    (agg_idle)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[SRC_XFER] = fire;
        set_vec[SRC_TM]   = tm_done;
        set_vec[SRC_LINK] = link_done;
        set_vec[SRC_ERR]  = err_evt;
        clr_vec           = (wr_en && hit_stat) ? wdata[NSRC-1:0] : '0;
    end

    irq_agg_status #(.NBITS(NSRC)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .stat    (stat_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            thr_q <= '0;
            tmo_q <= '0;
            aon_q <= 1'b0;
        end else if (wr_en) begin
            if (hit_en)
                en_q <= wdata[NSRC-1:0];
            if (hit_agg) begin
                thr_q <= wdata[AGG_THR_LSB +: THR_W];
                tmo_q <= wdata[AGG_TMO_LSB +: TMO_W];
                aon_q <= wdata[AGG_EN_BIT];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (hit_stat)
            rd_val[NSRC-1:0] = stat_q;
        else if (hit_en)
            rd_val[NSRC-1:0] = en_q;
        else if (hit_agg) begin
            rd_val[AGG_THR_LSB +: THR_W] = thr_q;
            rd_val[AGG_TMO_LSB +: TMO_W] = tmo_q;
            rd_val[AGG_EN_BIT]           = aon_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_en)
            rdata_q <= rd_val;
    end

    assign rdata = rdata_q;
    assign irq   = |(stat_q & en_q);
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        xfer_done,
    input logic        tm_done,
    input logic        link_done,
    input logic        irq,
    input logic [3:0]  stat_q,
    input logic [3:0]  en_q,
    input logic        agg_on,
    input logic        agg_idle
);
    logic flush_wr, clr_wr;
    assign flush_wr = wr_en && (addr == OFS_AGG) && wdata[AGG_RST_BIT];
    assign clr_wr   = wr_en && (addr == OFS_STAT);

    a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_q != 4'b0));

    a_r3_tm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tm_done |=> stat_q[SRC_TM]);

    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (link_done && clr_wr && wdata[SRC_LINK]) |=> stat_q[SRC_LINK]);

    a_r1_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && wdata[SRC_LINK] && !link_done) |=> !stat_q[SRC_LINK]);

    a_r5_bypass_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && agg_idle && !agg_on && !flush_wr) |=> stat_q[SRC_XFER]);

    a_r8_flush_idles: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> agg_idle);

    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind irq_agg_top irq_agg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .xfer_done (xfer_done),
    .tm_done   (tm_done),
    .link_done (link_done),
    .irq       (irq),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .agg_on    (aon_q),
    .agg_idle  (agg_idle)
);

// File: tb/sim_irq_agg_top.sv
module sim_irq_agg_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic [31:0] rdata;
    logic        xfer_done = 1'b0, tm_done = 1'b0, link_done = 1'b0, err_evt = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    irq_agg_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .xfer_done(xfer_done), .tm_done(tm_done),
        .link_done(link_done), .err_evt(err_evt), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    int          m_stat, m_en, m_thr, m_tmo, m_aon, m_busy, m_cnt, m_tmr;
    logic [31:0] m_rdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stat = 0; m_en = 0; m_thr = 0; m_tmo = 0; m_aon = 0;
            m_busy = 0; m_cnt = 0; m_tmr = 0; m_rdata = '0;
        end else begin
            int fire, clr;
            fire = 0;
            if (wr_en && addr == 32'h28 && wdata[16]) begin
                m_busy = 0; m_cnt = 0; m_tmr = 0;
            end else if (m_busy == 0) begin
                if (xfer_done) begin
                    if (m_aon == 0 || m_thr <= 1) fire = 1;
                    else begin m_busy = 1; m_cnt = 1; m_tmr = 0; end
                end
            end else begin
                m_cnt = m_cnt + int'(xfer_done);
                m_tmr = m_tmr + 1;
                if (m_cnt >= m_thr || (m_tmo != 0 && m_tmr >= m_tmo)) begin
                    fire = 1; m_busy = 0; m_cnt = 0; m_tmr = 0;
                end
            end
            if (rd_en) begin
                if (addr == 32'h20)      m_rdata = 32'(m_stat);
                else if (addr == 32'h24) m_rdata = 32'(m_en);
                else if (addr == 32'h28) m_rdata = (32'(m_aon) << 31) | (32'(m_tmo) << 8) | 32'(m_thr);
                else                     m_rdata = '0;
            end
            clr = (wr_en && addr == 32'h20) ? int'(wdata[3:0]) : 0;
            m_stat = (m_stat & ~clr) | fire | (int'(tm_done) << 1)
                     | (int'(link_done) << 2) | (int'(err_evt) << 3);
            if (wr_en && addr == 32'h24) m_en = int'(wdata[3:0]);
            if (wr_en && addr == 32'h28) begin
                m_thr = int'(wdata[4:0]); m_tmo = int'(wdata[15:8]); m_aon = int'(wdata[31]);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq == (|(m_stat[3:0] & m_en[3:0])), "R2 irq vs model", 32'(irq),
                32'(|(m_stat[3:0] & m_en[3:0])));
            chk(rdata == m_rdata, "R11 rdata vs model", rdata, m_rdata);
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; addr = '0;
        chk(rdata == exp, tag, rdata, exp);
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        xfer_done = m[0]; tm_done = m[1]; link_done = m[2]; err_evt = m[3];
        @(negedge clk);
        xfer_done = 1'b0; tm_done = 1'b0; link_done = 1'b0; err_evt = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(irq == 1'b0, "R10 irq in reset", 32'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdata == 0, "R10 rdata after reset", rdata, 0);
        rd(32'h20, 0, "R10 status reset");
        rd(32'h24, 0, "R10 enable reset");
        rd(32'h28, 0, "R10 agg ctrl reset");

        wr(32'h24, 32'hFFFF_FFFF);
        rd(32'h24, 32'hF, "R2 enable reserved bits");
        pulse(4'b0010);
        rd(32'h20, 32'h2, "R3 tm sets bit1");
        chk(irq == 1'b1, "R2 irq on enabled bit", 32'(irq), 1);
        wr(32'h20, 32'h0);
        rd(32'h20, 32'h2, "R1 zero write no effect");
        wr(32'h20, 32'h2);
        rd(32'h20, 32'h0, "R1 w1c clears");
        pulse(4'b1100);
        rd(32'h20, 32'hC, "R3 link and err");
        wr(32'h20, 32'hFFFF_FFFF);
        rd(32'h20, 32'h0, "R1 clear all");

        wr(32'h24, 32'h1);
        pulse(4'b0010);
        chk(irq == 1'b0, "R2 masked source", 32'(irq), 0);
        wr(32'h20, 32'h2);
        wr(32'h24, 32'hF);

        pulse(4'b0001);
        rd(32'h20, 32'h1, "R5 aggregation off");
        wr(32'h20, 32'h1);
        wr(32'h28, 32'h8000_0000);
        rd(32'h28, 32'h8000_0000, "R4 ctrl readback");
        pulse(4'b0001);
        rd(32'h20, 32'h1, "R5 threshold zero");
        wr(32'h20, 32'h1);

        wr(32'h28, 32'h8000_0003);
        pulse(4'b0001); pulse(4'b0001);
        rd(32'h20, 32'h0, "R6 below threshold");
        pulse(4'b0001);
        rd(32'h20, 32'h1, "R6 threshold reached");
        wr(32'h20, 32'h1);

        wr(32'h28, 32'h8001_0003);
        rd(32'h28, 32'h8000_0003, "R4 flush bit reads zero");
        pulse(4'b0001); pulse(4'b0001);
        wr(32'h28, 32'h8001_0003);
        pulse(4'b0001); pulse(4'b0001);
        rd(32'h20, 32'h0, "R8 flush discards group");
        pulse(4'b0001);
        rd(32'h20, 32'h1, "R8 new group completes");
        wr(32'h20, 32'h1);

        pulse(4'b0001);
        @(negedge clk);
        wr_en = 1'b1; addr = 32'h28; wdata = 32'h8001_0003; xfer_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0; xfer_done = 1'b0;
        pulse(4'b0001); pulse(4'b0001);
        rd(32'h20, 32'h0, "R8 flush-edge completion dropped");
        pulse(4'b0001);
        rd(32'h20, 32'h1, "R8 group after dropped completion");
        wr(32'h20, 32'h1);

        wr(32'h28, 32'h8000_0A05);
        pulse(4'b0001);
        repeat (7) @(negedge clk);
        rd(32'h20, 32'h0, "R7 before timeout");
        rd(32'h20, 32'h1, "R7 timeout fires");
        wr(32'h20, 32'h1);

        wr(32'h28, 32'h0);
        @(negedge clk);
        wr_en = 1'b1; addr = 32'h20; wdata = 32'h3; tm_done = 1'b1; xfer_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0; tm_done = 1'b0; xfer_done = 1'b0;
        rd(32'h20, 32'h3, "R9 set beats clear");
        wr(32'h20, 32'h3);

        rd(32'h2C, 32'h0, "R11 unmapped reads zero");
        repeat (3) @(negedge clk);
        chk(rdata == 0, "R11 rdata holds", rdata, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule